// File: doc/BRIEF.md
# Serial Character Transmitter with Sixteenth-Bit Stop Control

This block turns parallel characters of 5 to 8 bits into an asynchronous serial stream on `txd`. A one-entry holding register takes each character from a valid/data write and hands it to a shift stage. The shift stage sends a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. All timing comes from `tick16`, a clock enable that pulses sixteen times per bit. The stop period is set in sixteenths of a bit through a 4-bit code, and its meaning depends on the character length. A one-tick-per-bit mode serves an external 1x rate clock.

Two modem lines are handled. Clear-to-send gating makes the transmitter check `cts` only at the moment a character could begin. Automatic request-to-send release drops `rts` one bit time after a disabled transmitter has sent everything it holds. `tx_rdy` tells the writer that the holding register is free. `tx_emp` tells it that the line has gone quiet.

Top module: `uart_frac_tx`

## Requirements
- R1: While and after reset, `txd` = 1, `rts` = 0, `tx_rdy` = 1 and `tx_emp` = 1.
- R2: A frame is one start bit (0), then the data bits least significant first, then the stop period (1). With `one_x` = 0 each start, data and parity bit lasts 16 `tick16` pulses. `char_len` 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits.
- R3: With `par_en` = 1, a parity bit follows the last data bit. With `par_odd` = 0 the count of ones in data plus parity is even; with `par_odd` = 1 it is odd.
- R4: For 6, 7 or 8 data bits and a `stop_code` value n from 0 to 7, the stop period lasts 9+n ticks.
- R5: For 5 data bits with n from 0 to 7, and for any length with n from 8 to 15, the stop period lasts 17+n ticks.
- R6: With `one_x` = 1, every bit lasts one tick. The stop period is 1 tick when `stop_code[3]` = 0 and 2 ticks when it is 1.
- R7: `tx_rdy` is 1 exactly when the holding register is empty. A write is taken when `wr_valid`, `tx_rdy` and `tx_en` are all 1, and `tx_rdy` drops on the next cycle. A write while `tx_en` = 0 is ignored.
- R8: `tx_emp` is 1 only when the holding register is empty and the stop period has ended. A character waiting in the holding register starts on the tick that ends the previous stop period, so there is no idle gap.
- R9: With `cts_gate` = 1, a character starts only if `cts` = 1 at the tick where it could begin. Until then `txd` stays 1 and the character stays in the holding register. A drop of `cts` after the start bit has begun does not change that frame.
- R10: With `cts_gate` = 0, `cts` has no effect, and a written character starts within two ticks on an idle line.
- R11: A one-cycle pulse on `rts_set` drives `rts` to 1. With `rts_auto` = 1, `rx_rts_ctl` = 0 and `tx_en` = 0, `rts` falls exactly one bit time (16 ticks, or 1 tick when `one_x` = 1) after the tick on which `tx_emp` rose.
- R12: With `rts_auto` = 0, or with `rx_rts_ctl` = 1, the transmitter never clears `rts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Bit-rate enable, 16 pulses per bit |
| tx_en | input | 1 | Transmitter enable; gates new writes |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Character to send, right-aligned |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_code | input | 4 | Stop period length code |
| one_x | input | 1 | One tick per bit (external 1x clock) |
| cts_gate | input | 1 | Enable clear-to-send gating |
| cts | input | 1 | Clear to send, active high |
| rts_auto | input | 1 | Enable automatic RTS release |
| rx_rts_ctl | input | 1 | Receiver also claims RTS control |
| rts_set | input | 1 | Pulse to assert RTS |
| txd | output | 1 | Serial data out, idles high |
| rts | output | 1 | Request to send, active high |
| tx_rdy | output | 1 | Holding register empty |
| tx_emp | output | 1 | Holding and shift stages empty |

## Verification
Every `txd` transition happens on the clock edge that carries a `tick16` pulse. The bench therefore takes one sample on the falling edge after each tick. It counts ticks from the start bit and reads each bit at its midpoint. It also checks that the stop level holds for exactly the expected number of ticks. `tx_rdy` is due one clock after an accepted write, and the bench reads it on the next falling edge. The fall of `rts` is due 16 ticks after the first sample that shows `tx_emp` high, and the bench counts those samples one by one to confirm it.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    localparam int DATA_W   = 8;
    localparam int CODE_W   = 4;
    localparam int OVS      = 16;
    localparam int CNT_W    = $clog2(2 * OVS) + 1;
    localparam int BT_W     = $clog2(OVS) + 1;
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int NB_W     = $clog2(DATA_W) + 1;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0]        len;
        logic              par_en;
        logic              par_odd;
        logic [CODE_W-1:0] stop_code;
        logic              one_x;
        logic              cts_gate;
    } tx_cfg_t;

    typedef struct packed {
        logic [NB_W-1:0]  nbits;
        logic             par_en;
        logic             par_bit;
        logic [CNT_W-1:0] stop_ticks;
        logic [BT_W-1:0]  bit_ticks;
    } frame_t;

    function automatic logic [NB_W-1:0] f_nbits(input logic [1:0] len);
        return NB_W'(MIN_BITS) + NB_W'(len);
    endfunction

    function automatic logic f_parity(input logic [DATA_W-1:0] d,
                                      input logic [1:0] len,
                                      input logic odd);
        logic [DATA_W-1:0] m;
        m = {DATA_W{1'b1}} >> (2'd3 - len);
        return (^(d & m)) ^ odd;
    endfunction

    function automatic logic [BT_W-1:0] f_bit_ticks(input logic one_x);
        return one_x ? BT_W'(1) : BT_W'(OVS);
    endfunction

    function automatic logic [CNT_W-1:0] f_stop_ticks(input logic [CODE_W-1:0] code,
                                                      input logic [1:0] len,
                                                      input logic one_x);
        if (one_x)
            return code[CODE_W-1] ? CNT_W'(2) : CNT_W'(1);
        else if (code[CODE_W-1] || (len == 2'd0))
            return CNT_W'(OVS + 1) + CNT_W'(code);
        else
            return CNT_W'(OVS / 2 + 1) + CNT_W'(code);
    endfunction

endpackage

// File: rtl/uftx_hold.sv
module uftx_hold
    import uftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              load,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic take;
    assign take = wr_valid && tx_en && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (load) begin
            full <= 1'b0;
        end
    end

    AST_LOAD_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        load |-> full);  // R7

endmodule

// File: rtl/uftx_shifter.sv
module uftx_shifter
    import uftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tx_cfg_t           cfg,
    input  logic              cts,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              load,
    output logic              txd,
    output logic              busy
);

    tx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    frame_t            fr_q;
    frame_t            fr_new;
    logic              can_start;
    logic [CNT_W-1:0]  limit;
    logic              last;
    logic              start_now;

    assign can_start = hold_full && (!cfg.cts_gate || cts);
    assign limit = (state_q == ST_STOP) ? (fr_q.stop_ticks - CNT_W'(1))
                                        : (CNT_W'(fr_q.bit_ticks) - CNT_W'(1));
    assign last = (cnt_q == limit);
    assign start_now = tick && can_start &&
                       ((state_q == ST_IDLE) || ((state_q == ST_STOP) && last));
    assign load = start_now;
    assign busy = (state_q != ST_IDLE);

    always_comb begin
        fr_new.nbits      = f_nbits(cfg.len);
        fr_new.par_en     = cfg.par_en;
        fr_new.par_bit    = f_parity(hold_data, cfg.len, cfg.par_odd);
        fr_new.stop_ticks = f_stop_ticks(cfg.stop_code, cfg.len, cfg.one_x);
        fr_new.bit_ticks  = f_bit_ticks(cfg.one_x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            fr_q    <= '0;
            txd     <= 1'b1;
        end else if (start_now) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= hold_data;
            fr_q    <= fr_new;
            txd     <= 1'b0;
        end else if (tick && (state_q != ST_IDLE)) begin
            if (!last) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else begin
                cnt_q <= '0;
                case (state_q)
                    ST_START: begin
                        state_q <= ST_DATA;
                        txd     <= sh_q[0];
                    end
                    ST_DATA: begin
                        if (idx_q == IDX_W'(fr_q.nbits - NB_W'(1))) begin
                            if (fr_q.par_en) begin
                                state_q <= ST_PAR;
                                txd     <= fr_q.par_bit;
                            end else begin
                                state_q <= ST_STOP;
                                txd     <= 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            sh_q  <= sh_q >> 1;
                            txd   <= sh_q[1];
                        end
                    end
                    ST_PAR: begin
                        state_q <= ST_STOP;
                        txd     <= 1'b1;
                    end
                    default: begin
                        state_q <= ST_IDLE;
                        txd     <= 1'b1;
                    end
                endcase
            end
        end
    end

    AST_CTS_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cfg.cts_gate && !cts) |=> txd);  // R9

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        load |=> (!txd && state_q == ST_START));  // R2

endmodule

// File: rtl/uftx_rts.sv
module uftx_rts
    import uftx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rts_set,
    input  logic auto_en,
    input  logic rx_ctl,
    input  logic tx_en,
    input  logic tx_emp,
    input  logic one_x,
    output logic rts
);

    logic [BT_W-1:0] cnt_q;
    logic [BT_W-1:0] bit_ticks;
    logic            armed;

    assign bit_ticks = f_bit_ticks(one_x);
    assign armed = auto_en && !rx_ctl && !tx_en && tx_emp && rts;

    always_ff @(posedge clk) begin
        if (rst) begin
            rts   <= 1'b0;
            cnt_q <= '0;
        end else if (rts_set) begin
            rts   <= 1'b1;
            cnt_q <= '0;
        end else if (!armed) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == bit_ticks - BT_W'(1)) begin
                rts   <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + BT_W'(1);
            end
        end
    end

    AST_RTS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rts && (!auto_en || rx_ctl)) |=> rts);  // R12

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
    import uftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [CODE_W-1:0] stop_code,
    input  logic              one_x,
    input  logic              cts_gate,
    input  logic              cts,
    input  logic              rts_auto,
    input  logic              rx_rts_ctl,
    input  logic              rts_set,
    output logic              txd,
    output logic              rts,
    output logic              tx_rdy,
    output logic              tx_emp
);

    tx_cfg_t           cfg;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              busy;

    always_comb begin
        cfg.len       = char_len;
        cfg.par_en    = par_en;
        cfg.par_odd   = par_odd;
        cfg.stop_code = stop_code;
        cfg.one_x     = one_x;
        cfg.cts_gate  = cts_gate;
    end

    uftx_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .tx_en    (tx_en),
        .load     (load),
        .full     (hold_full),
        .data     (hold_data)
    );

    uftx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .cfg       (cfg),
        .cts       (cts),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .load      (load),
        .txd       (txd),
        .busy      (busy)
    );

    assign tx_rdy = !hold_full;
    assign tx_emp = !hold_full && !busy;

    uftx_rts u_rts (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .rts_set (rts_set),
        .auto_en (rts_auto),
        .rx_ctl  (rx_rts_ctl),
        .tx_en   (tx_en),
        .tx_emp  (tx_emp),
        .one_x   (one_x),
        .rts     (rts)
    );

    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_emp |-> txd);  // R8

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && tx_rdy && tx_en) |=> !tx_rdy);  // R7

    AST_DISABLED_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && tx_rdy) |=> tx_rdy);  // R7

    AST_RTS_DROP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rts) |-> tx_emp);  // R11

endmodule

// File: tb/uart_frac_tx_test.sv
module uart_frac_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       tx_en = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [3:0] stop_code = 4'd0;
    logic       one_x = 1'b0;
    logic       cts_gate = 1'b0;
    logic       cts = 1'b0;
    logic       rts_auto = 1'b0;
    logic       rx_rts_ctl = 1'b0;
    logic       rts_set = 1'b0;
    logic       txd, rts, tx_rdy, tx_emp;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pe;
        bit         po;
        int         s;
        int         b;
        string      rq;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    uart_frac_tx uut (
        .clk(clk), .rst(rst), .tick16(tick16), .tx_en(tx_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .char_len(char_len),
        .par_en(par_en), .par_odd(par_odd), .stop_code(stop_code),
        .one_x(one_x), .cts_gate(cts_gate), .cts(cts),
        .rts_auto(rts_auto), .rx_rts_ctl(rx_rts_ctl), .rts_set(rts_set),
        .txd(txd), .rts(rts), .tx_rdy(tx_rdy), .tx_emp(tx_emp)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic next_tick(output logic v);
        do @(posedge clk); while (tick16 !== 1'b1);
        @(negedge clk);
        v = txd;
    endtask

    function automatic int exp_stop(input int code, input int nb, input bit x1);
        if (x1) return (code >= 8) ? 2 : 1;
        if (code >= 8 || nb == 5) return 17 + code;
        return 9 + code;
    endfunction

    function automatic logic exp_bit(input item_t it, input int j);
        logic [7:0] m;
        if (j == 0) return 1'b0;
        if (j <= it.nb) return it.d[j-1];
        m = 8'((1 << it.nb) - 1);
        return (^(it.d & m)) ^ it.po;
    endfunction

    // driver: pushes the expected frame, then writes the character
    task automatic send(input logic [7:0] d, input string rq);
        item_t it;
        it.d  = d;
        it.nb = 5 + int'(char_len);
        it.pe = par_en;
        it.po = par_odd;
        it.s  = exp_stop(int'(stop_code), it.nb, one_x);
        it.b  = one_x ? 1 : 16;
        it.rq = rq;
        @(negedge clk);
        while (!tx_rdy) @(negedge clk);
        q.push_back(it);
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!(tx_emp && q.size() == 0));
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        logic v;
        for (int i = 0; i < n; i++) next_tick(v);
    endtask

    // monitor: decodes txd tick by tick and compares with the queue
    initial begin
        logic  v;
        bit    pend;
        item_t it;
        int    nbit, errs, hi;
        pend = 0;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            if (!pend) begin
                do next_tick(v); while (v !== 1'b0);
            end
            pend = 0;
            if (q.size() == 0) begin
                check(0, "R7", "start with no character written", 1, 0);
                continue;
            end
            it = q.pop_front();
            nbit = 1 + it.nb + (it.pe ? 1 : 0);
            errs = 0;
            for (int k = 1; k < it.b * nbit; k++) begin
                next_tick(v);
                if ((k % it.b) == (it.b / 2) && v !== exp_bit(it, k / it.b))
                    errs++;
            end
            check(errs == 0, it.rq, "frame bit mismatches", errs, 0);
            hi = 0;
            for (int i = 0; i < it.s; i++) begin
                next_tick(v);
                if (v === 1'b1) hi++;
            end
            check(hi == it.s, it.rq, "stop ticks held high", hi, it.s);
            next_tick(v);
            if (v === 1'b0) pend = 1;
            else if (q.size() == 0)
                check(tx_emp === 1'b1, "R8", "tx_emp after stop", int'(tx_emp), 1);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic v;
        int   n, lows;
        repeat (4) @(negedge clk);
        check(txd === 1'b1 && rts === 1'b0, "R1", "txd/rts in reset",
              int'({txd, rts}), 2);
        rst = 1'b0;
        @(negedge clk);
        check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(rts === 1'b0, "R1", "rts after reset", int'(rts), 0);
        check(tx_rdy === 1'b1, "R1", "tx_rdy after reset", int'(tx_rdy), 1);
        check(tx_emp === 1'b1, "R1", "tx_emp after reset", int'(tx_emp), 1);

        // R2 R4: 8 bits, no parity, stop 9 ticks
        char_len = 2'd3; stop_code = 4'd0;
        send(8'hA5, "R4");
        check(tx_emp === 1'b0, "R8", "tx_emp while sending", int'(tx_emp), 0);
        wait_done();

        // R3 R4: 8 bits even parity, stop 16 ticks
        par_en = 1'b1; par_odd = 1'b0; stop_code = 4'd7;
        send(8'h3D, "R3");
        wait_done();

        // R5: 5 bits odd parity, code 0 gives 17 ticks
        char_len = 2'd0; par_odd = 1'b1; stop_code = 4'd0;
        send(8'h15, "R5");
        wait_done();

        // R5 R8: 6 bits, code 8 gives 25 ticks, back to back
        char_len = 2'd1; par_en = 1'b0; stop_code = 4'd8;
        send(8'h2A, "R5");
        send(8'h15, "R8");
        check(tx_rdy === 1'b0, "R7", "tx_rdy after second write", int'(tx_rdy), 0);
        wait_done();

        // R5: 7 bits, code 15 gives 32 ticks
        char_len = 2'd2; stop_code = 4'd15;
        send(8'h5B, "R5");
        send(8'h24, "R5");
        wait_done();

        // R6: one tick per bit
        one_x = 1'b1; char_len = 2'd3; par_en = 1'b1; par_odd = 1'b0; stop_code = 4'd0;
        send(8'hC6, "R6");
        send(8'h39, "R6");
        wait_done();
        stop_code = 4'd8;
        send(8'h71, "R6");
        send(8'h0E, "R6");
        wait_done();
        one_x = 1'b0; par_en = 1'b0; stop_code = 4'd0;

        // R7: write with transmitter disabled is ignored
        tx_en = 1'b0;
        wr_data = 8'hFF; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        @(negedge clk);
        check(tx_rdy === 1'b1, "R7", "tx_rdy after disabled write", int'(tx_rdy), 1);
        wait_ticks(40);
        check(tx_emp === 1'b1 && txd === 1'b1, "R7", "line idle after disabled write",
              int'({tx_emp, txd}), 3);
        tx_en = 1'b1;

        // R9: CTS gating holds the start
        cts_gate = 1'b1; cts = 1'b0;
        send(8'h5A, "R9");
        lows = 0;
        for (int i = 0; i < 50; i++) begin
            next_tick(v);
            if (v !== 1'b1) lows++;
        end
        check(lows == 0, "R9", "txd low ticks while cts low", lows, 0);
        check(tx_rdy === 1'b0, "R9", "character kept in holding", int'(tx_rdy), 0);
        cts = 1'b1;
        do next_tick(v); while (v !== 1'b0);
        cts = 1'b0;   // mid-frame drop must not disturb the frame
        wait_done();

        // R10: gating off, cts ignored
        cts_gate = 1'b0; cts = 1'b0;
        send(8'h81, "R10");
        n = 0;
        do begin next_tick(v); n++; end while (v !== 1'b0 && n < 40);
        check(n <= 2, "R10", "ticks to start with cts low", n, 2);
        wait_done();

        // R11 R12: RTS control
        rts_set = 1'b1;
        @(negedge clk);
        rts_set = 1'b0;
        check(rts === 1'b1, "R11", "rts after set pulse", int'(rts), 1);
        rts_auto = 1'b1; rx_rts_ctl = 1'b1;
        send(8'h33, "R12");
        tx_en = 1'b0;
        wait_done();
        wait_ticks(30);
        check(rts === 1'b1, "R12", "rts with receiver also in control", int'(rts), 1);
        rts_auto = 1'b0; rx_rts_ctl = 1'b0;
        wait_ticks(30);
        check(rts === 1'b1, "R12", "rts with auto release off", int'(rts), 1);

        tx_en = 1'b1; rts_auto = 1'b1;
        send(8'hC3, "R11");
        tx_en = 1'b0;
        do next_tick(v); while (tx_emp !== 1'b1);
        n = 0;
        do begin next_tick(v); n++; end while (rts !== 1'b0 && n < 40);
        check(n == 16, "R11", "ticks from tx_emp to rts drop", n, 16);
        rts_auto = 1'b0;

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R2", "frames left undelivered", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule